// File: doc/BRIEF.md
# Receive FIFO with Automatic RTS Hysteresis

This block pairs a 64-entry receive byte queue with a controller that drives the active-low RTS pin from the queue's fill level. Software supplies one 8-bit threshold register that packs a stop level and a restart level. Each field is multiplied by four to give a level in entries. When the queue fills to the stop level, RTS is raised on the pin, which tells the remote transmitter to pause. RTS stays raised until reads bring the level back down to the restart level. The gap between the two levels gives hysteresis, so the pin does not toggle on every byte.

The thresholds can also come from a 2-bit receive trigger code instead of the packed register. With automatic mode off, the pin follows a software-controlled RTS bit. A remote transmitter may already be sending one more character when RTS rises. The queue stores that character like any other, and only a write into a completely full queue counts as an overrun.

Top module: `uart_rts_flow`

## Requirements
- R1: With `trig_sel`=0, the stop level is `thr_reg[3:0]`×4 and the restart level is `thr_reg[7:4]`×4, both counted in entries.
- R2: In automatic mode, when `fifo_level` becomes at least the stop level, `rts_n` goes to 1 at the next clock edge, and not earlier.
- R3: Once stopped, when `fifo_level` falls to the restart level or below (and is below the stop level), `rts_n` goes to 0 at the next clock edge, and not earlier.
- R4: While the level lies strictly between the restart and stop levels, `rts_n` keeps its previous value.
- R5: With `auto_rts_en`=0, `rts_n` takes the inverse of `sw_rts` at each clock edge. Reset drives `rts_n`=1, `rts_halted`=0, `overrun`=0 and `fifo_level`=0.
- R6: If the programmed restart level is not below the stop level, the block uses the stop level minus 4 as the restart level, or 0 when the stop level is 0.
- R7: The queue accepts writes regardless of `rts_n` while it holds fewer than 64 bytes, so a byte that arrives after RTS rises is stored without setting `overrun`. Bytes are read back in the order they were written.
- R8: A write while `fifo_level` is 64 is discarded and sets `overrun`, which stays set until reset.
- R9: A read while the queue is empty leaves `rd_data` and `fifo_level` unchanged.
- R10: With `trig_sel`=1, the stop level is 8, 16, 32 or 56 for `trig_code` 0, 1, 2 or 3, and the restart level is the stop level minus 4.
- R11: `rts_halted` is 1 exactly while automatic mode holds the transmitter stopped. Whenever it is 1, `rts_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store `wr_data` in the queue |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | Pop one byte from the queue |
| rd_data | output | 8 | Byte popped by the most recent successful read |
| fifo_level | output | 7 | Number of bytes held, 0 to 64 |
| auto_rts_en | input | 1 | 1 selects automatic RTS control |
| sw_rts | input | 1 | Software RTS request, used when automatic mode is off (1 asserts RTS) |
| thr_reg | input | 8 | Packed thresholds: restart in [7:4], stop in [3:0] |
| trig_sel | input | 1 | 1 takes thresholds from `trig_code` instead of `thr_reg` |
| trig_code | input | 2 | Receive trigger code |
| rts_n | output | 1 | RTS pin, active low |
| rts_halted | output | 1 | Automatic mode is holding the transmitter stopped |
| overrun | output | 1 | Sticky flag for a write into a full queue |

## Verification
If the hysteresis state register is corrupted, `rts_n` shows the wrong value at the very next edge. The wrong value persists until the level crosses the other threshold. For that reason the checks sample the pin one edge after each level change near a threshold. A fault in the level counter moves the stop and restart points by one byte or more. It also shifts the order or content of the bytes read back, so the bench writes distinct byte values and checks each one as it comes out. A fault in the overrun path is visible in the flag right after the 65th write, and in the last byte read out of the queue.

// File: rtl/rts_flow_pkg.sv
package rts_flow_pkg;

  typedef enum logic {FLOW_GO = 1'b0, FLOW_STOP = 1'b1} flow_state_e;

  // Threshold field to entry count.
  function automatic int scale_thr(input int field, input int step);
    return field * step;
  endfunction

  // Restart level actually used. It is forced below the stop level.
  function automatic int eff_resume(input int halt, input int res, input int step);
    if (res < halt)        return res;
    else if (halt >= step) return halt - step;
    else                   return 0;
  endfunction

  // Stop level selected by the receive trigger code.
  function automatic int trig_level(input int code, input int depth);
    case (code)
      0:       return depth / 8;
      1:       return depth / 4;
      2:       return depth / 2;
      default: return depth - 8;
    endcase
  endfunction

endpackage

// File: rtl/rts_rxq.sv
module rts_rxq #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [LW-1:0] level,
  output logic          overrun
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          full, empty, wr_ok, rd_ok;

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      level   <= '0;
      rd_data <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) begin
        rptr    <= rptr + 1'b1;
        rd_data <= mem[rptr];
      end
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (wr_en && full) overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/rts_thr_sel.sv
module rts_thr_sel
  import rts_flow_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int STEP     = 4,
  parameter bit HAS_TRIG = 1'b1,
  localparam int LW      = $clog2(DEPTH) + 1
) (
  input  logic [7:0]    thr_reg,
  input  logic          trig_sel,
  input  logic [1:0]    trig_code,
  output logic [LW-1:0] halt_lvl,
  output logic [LW-1:0] resume_lvl
);

  int reg_halt, reg_res;

  always_comb begin
    reg_halt = scale_thr(int'(thr_reg[3:0]), STEP);
    reg_res  = eff_resume(reg_halt, scale_thr(int'(thr_reg[7:4]), STEP), STEP);
  end

  generate
    if (HAS_TRIG) begin : g_trig
      int trg_halt;
      always_comb begin
        trg_halt = trig_level(int'(trig_code), DEPTH);
        if (trig_sel) begin
          halt_lvl   = LW'(trg_halt);
          resume_lvl = LW'(eff_resume(trg_halt, trg_halt, STEP));
        end else begin
          halt_lvl   = LW'(reg_halt);
          resume_lvl = LW'(reg_res);
        end
      end
    end else begin : g_reg_only
      logic unused_trig;
      assign unused_trig = trig_sel ^ (^trig_code);
      assign halt_lvl    = LW'(reg_halt);
      assign resume_lvl  = LW'(reg_res);
    end
  endgenerate

endmodule

// File: rtl/rts_hyst.sv
module rts_hyst
  import rts_flow_pkg::*;
#(
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_en,
  input  logic          sw_rts,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] halt_lvl,
  input  logic [LW-1:0] resume_lvl,
  output logic          rts_n,
  output logic          halted
);

  flow_state_e state, nxt;
  logic        halt_hit, resume_hit;

  assign halt_hit   = (level >= halt_lvl);
  assign resume_hit = (level <= resume_lvl);

  always_comb begin
    nxt = state;
    case (state)
      FLOW_GO:   if (halt_hit) nxt = FLOW_STOP;
      FLOW_STOP: if (resume_hit && !halt_hit) nxt = FLOW_GO;
      default:   nxt = FLOW_GO;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FLOW_GO;
      rts_n <= 1'b1;
    end else if (auto_en) begin
      state <= nxt;
      rts_n <= (nxt == FLOW_STOP);
    end else begin
      state <= FLOW_GO;
      rts_n <= !sw_rts;
    end
  end

  assign halted = (state == FLOW_STOP);

endmodule

// File: rtl/uart_rts_flow.sv
module uart_rts_flow #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int STEP  = 4,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  output logic [LVL_W-1:0] fifo_level,
  input  logic             auto_rts_en,
  input  logic             sw_rts,
  input  logic [7:0]       thr_reg,
  input  logic             trig_sel,
  input  logic [1:0]       trig_code,
  output logic             rts_n,
  output logic             rts_halted,
  output logic             overrun
);

  logic [LVL_W-1:0] halt_lvl, resume_lvl;

  rts_rxq #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .level   (fifo_level),
    .overrun (overrun)
  );

  rts_thr_sel #(.DEPTH(DEPTH), .STEP(STEP), .HAS_TRIG(1'b1)) u_thr (
    .thr_reg    (thr_reg),
    .trig_sel   (trig_sel),
    .trig_code  (trig_code),
    .halt_lvl   (halt_lvl),
    .resume_lvl (resume_lvl)
  );

  rts_hyst #(.LW(LVL_W)) u_hyst (
    .clk        (clk),
    .rst_n      (rst_n),
    .auto_en    (auto_rts_en),
    .sw_rts     (sw_rts),
    .level      (fifo_level),
    .halt_lvl   (halt_lvl),
    .resume_lvl (resume_lvl),
    .rts_n      (rts_n),
    .halted     (rts_halted)
  );

endmodule

// File: rtl/rts_flow_checker.sv
module rts_flow_checker #(
  parameter int LW    = 7,
  parameter int DW    = 8,
  parameter int DEPTH = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic [LW-1:0] fifo_level,
  input logic          auto_rts_en,
  input logic          sw_rts,
  input logic [LW-1:0] halt_lvl,
  input logic [LW-1:0] resume_lvl,
  input logic          rts_n,
  input logic          rts_halted,
  input logic          overrun
);

  p_stop_at_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && auto_rts_en && $past(auto_rts_en) && $past(fifo_level) >= $past(halt_lvl))
      |-> rts_n);

  p_go_at_resume_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && auto_rts_en && $past(auto_rts_en) &&
     $past(fifo_level) <= $past(resume_lvl) && $past(fifo_level) < $past(halt_lvl))
      |-> !rts_n);

  p_hold_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && auto_rts_en && $past(auto_rts_en) &&
     $past(fifo_level) > $past(resume_lvl) && $past(fifo_level) < $past(halt_lvl))
      |-> rts_n == $past(rts_n));

  p_manual_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(auto_rts_en)) |-> rts_n == !$past(sw_rts));

  p_resume_below_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_lvl != '0) |-> resume_lvl < halt_lvl);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(overrun)) |-> overrun);

  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && fifo_level == '0) |=> (fifo_level == '0 && $stable(rd_data)));

  p_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rts_halted |-> rts_n);

endmodule

bind uart_rts_flow rts_flow_checker #(.LW(LVL_W), .DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .fifo_level  (fifo_level),
  .auto_rts_en (auto_rts_en),
  .sw_rts      (sw_rts),
  .halt_lvl    (halt_lvl),
  .resume_lvl  (resume_lvl),
  .rts_n       (rts_n),
  .rts_halted  (rts_halted),
  .overrun     (overrun)
);

// File: tb/uart_rts_flow_test.sv
`timescale 1ns/1ps
module uart_rts_flow_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [6:0] fifo_level;
  logic       auto_rts_en = 1'b0, sw_rts = 1'b0, trig_sel = 1'b0;
  logic [7:0] thr_reg = '0;
  logic [1:0] trig_code = '0;
  logic       rts_n, rts_halted, overrun;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  uart_rts_flow uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .fifo_level(fifo_level), .auto_rts_en(auto_rts_en),
    .sw_rts(sw_rts), .thr_reg(thr_reg), .trig_sel(trig_sel), .trig_code(trig_code),
    .rts_n(rts_n), .rts_halted(rts_halted), .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic drain();
    while (fifo_level != 0) pop();
  endtask

  task automatic t_reset();
    chk("R5 reset rts_n", rts_n, 1);
    chk("R5 reset halted", rts_halted, 0);
    chk("R5 reset overrun", overrun, 0);
    chk("R5 reset level", fifo_level, 0);
  endtask

  task automatic t_manual();
    auto_rts_en = 1'b0; sw_rts = 1'b1;
    tick();
    chk("R5 sw assert", rts_n, 0);
    sw_rts = 1'b0;
    tick();
    chk("R5 sw release", rts_n, 1);
  endtask

  task automatic t_halt_resume();
    thr_reg = 8'h12;          // R1: stop 8, restart 4
    trig_sel = 1'b0; auto_rts_en = 1'b1;
    tick();
    chk("R3 auto go at empty", rts_n, 0);
    for (int i = 0; i < 7; i++) push(8'h10 + 8'(i));
    chk("R2 below stop", rts_n, 0);
    push(8'h17);
    chk("R1 level at stop", fifo_level, 8);
    chk("R2 not yet stopped", rts_n, 0);
    push(8'h18);              // extra in-flight byte
    chk("R2 stopped at stop level", rts_n, 1);
    chk("R11 halted flag", rts_halted, 1);
    chk("R7 extra byte stored", fifo_level, 9);
    chk("R7 no overrun", overrun, 0);
    for (int i = 0; i < 4; i++) begin
      pop();
      chk("R7 order", rd_data, 8'h10 + i);
    end
    chk("R4 hold at 5", rts_n, 1);
    pop();
    chk("R7 order", rd_data, 8'h14);
    chk("R3 not yet", rts_n, 1);
    tick();
    chk("R3 go at restart", rts_n, 0);
    chk("R11 flag clear", rts_halted, 0);
    drain();
  endtask

  task automatic t_clamp();
    thr_reg = 8'h33;          // R6: stop 12, restart clamped to 8
    for (int i = 0; i < 12; i++) push(8'(i));
    tick();
    chk("R6 stop at 12", rts_n, 1);
    for (int i = 0; i < 3; i++) pop();
    tick();
    chk("R6 hold at 9", rts_n, 1);
    pop();
    tick();
    chk("R6 go at 8", rts_n, 0);
    drain();
  endtask

  task automatic t_trig();
    trig_sel = 1'b1; trig_code = 2'd1;   // R10: stop 16, restart 12
    thr_reg = 8'h01;
    for (int i = 0; i < 15; i++) push(8'(i));
    tick();
    chk("R10 below 16", rts_n, 0);
    push(8'hAA);
    tick();
    chk("R10 stop at 16", rts_n, 1);
    for (int i = 0; i < 3; i++) pop();
    tick();
    chk("R10 hold at 13", rts_n, 1);
    pop();
    tick();
    chk("R10 go at 12", rts_n, 0);
    drain();
    trig_sel = 1'b0;
  endtask

  task automatic t_overrun_empty();
    auto_rts_en = 1'b0;
    for (int i = 0; i < 64; i++) push(8'(i + 1));
    chk("R7 full level", fifo_level, 64);
    chk("R8 no overrun yet", overrun, 0);
    push(8'hEE);
    chk("R8 level held", fifo_level, 64);
    chk("R8 overrun set", overrun, 1);
    drain();
    chk("R8 discarded byte absent", rd_data, 64);
    chk("R8 overrun sticky", overrun, 1);
    pop();
    chk("R9 empty read data", rd_data, 64);
    chk("R9 empty read level", fifo_level, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_manual();
    t_halt_resume();
    t_clamp();
    t_trig();
    t_overrun_empty();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule